// File: doc/BRIEF.md
# Bit-Field and Byte-Manipulation Unit

This block is a purely combinational execution unit for the bit-manipulation class of a RISC integer datapath. An operation code selects one of nine functions. The operand `src_a` is the main source. The operand `src_b` serves two roles: it carries the old destination value for a field deposit, and it supplies the amount for a register-driven rotate. Two 5-bit immediates carry a bit position (which also serves as the immediate rotate amount) and a field size. The unit returns one 32-bit result in the same cycle.

The functions are:
- counting of leading ones and of leading zeros;
- sign extension from a byte or from a halfword;
- swapping of the two bytes inside each halfword;
- field extract and field deposit;
- right rotation by an immediate amount or by a register amount.

All function units evaluate in parallel, and an output multiplexer picks one result. The extract, the deposit and both rotates share a single barrel rotator. The amount fed to that rotator depends on the operation.

Top module: `bfu_top`

## Requirements
- R1: With op_sel = 0, result is the count of consecutive 1 bits in src_a starting from bit 31. An all-ones src_a gives 32.
- R2: With op_sel = 1, result is the count of consecutive 0 bits in src_a starting from bit 31. An all-zeros src_a gives 32.
- R3: With op_sel = 2, result equals src_a[7:0], with bit 7 copied into bits 31:8.
- R4: With op_sel = 3, result equals src_a[15:0], with bit 15 copied into bits 31:16.
- R5: With op_sel = 4, result is {src_a[23:16], src_a[31:24], src_a[7:0], src_a[15:8]}, listed from most to least significant.
- R6: With op_sel = 5, position P = pos_imm and size S = size_imm + 1, result holds src_a[P+S-1:P] in its low S bits, with zeros above. This applies only when P+S <= 32.
- R7: With op_sel = 6, using the same P and S encoding as R6, result equals src_b with bits [P+S-1:P] replaced by src_a[S-1:0]. This applies only when P+S <= 32.
- R8: With op_sel = 7, result is src_a rotated right by pos_imm. The low bits that leave bit 0 re-enter at bit 31.
- R9: With op_sel = 8, result is src_a rotated right by src_b[4:0]. Bits 31:5 of src_b have no effect.
- R10: Any op_sel value from 9 to 15 gives a result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (see requirements) |
| src_a | input | 32 | Main source operand |
| src_b | input | 32 | Old destination value for a deposit, or rotate amount register |
| pos_imm | input | 5 | Field position, or immediate rotate amount |
| size_imm | input | 5 | Field size minus one |
| result | output | 32 | Operation result |

## Verification
The extract, the deposit and both rotates all pass through the same rotator in the same evaluation. The risk is that the amount multiplexer feeds one operation the amount meant for another, for example the negated position that a deposit uses. The bench holds `src_a`, `src_b` and the immediates fixed and steps `op_sel` through extract, deposit, immediate rotate and register rotate on successive cycles. It judges each result against a bench function that works bit by bit, with no shifter at all. Random operands for the register rotate have non-zero upper bits in `src_b`, and directed corner cases add the full-width field and the topmost byte.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
   typedef enum logic [3:0] {
      OP_LEAD1   = 4'd0,
      OP_LEAD0   = 4'd1,
      OP_SXT8    = 4'd2,
      OP_SXT16   = 4'd3,
      OP_HSWAP   = 4'd4,
      OP_XTRACT  = 4'd5,
      OP_DEPOSIT = 4'd6,
      OP_RORI    = 4'd7,
      OP_RORV    = 4'd8
   } bfu_op_e;
endpackage

// File: rtl/bfu_lead_count.sv
module bfu_lead_count #(
   parameter int W  = 32,
   parameter int CW = $clog2(W) + 1
) (
   input  logic [W-1:0]  vec,
   input  logic          match,
   output logic [CW-1:0] cnt
);
   logic hit;

   always_comb begin
      cnt = '0;
      hit = 1'b0;
      for (int i = W - 1; i >= 0; i--) begin
         if (!hit) begin
            if (vec[i] == match) cnt = cnt + CW'(1);
            else                 hit = 1'b1;
         end
      end
   end

   // R1/R2: the bit just below the counted run breaks it; the count never exceeds W
   always_comb begin
      if (!$isunknown({vec, match})) begin
         assert_cnt_range_R2: assert (int'(cnt) <= W);
         if (int'(cnt) < W)
            assert_stop_bit_R1: assert (vec[W - 1 - int'(cnt)] != match);
      end
   end
endmodule

// File: rtl/bfu_rotr.sv
module bfu_rotr #(
   parameter int W  = 32,
   parameter int AW = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [AW-1:0] amt,
   output logic [W-1:0]  dout
);
   logic [W-1:0] stg [AW+1];

   assign stg[0] = din;

   for (genvar s = 0; s < AW; s++) begin : g_stage
      localparam int SH = 1 << s;
      assign stg[s+1] = amt[s] ? {stg[s][SH-1:0], stg[s][W-1:SH]} : stg[s];
   end

   assign dout = stg[AW];

   // R8: a rotation neither creates nor loses set bits
   always_comb begin
      if (!$isunknown({din, amt}))
         assert_bits_kept_R8: assert ($countones(dout) == $countones(din));
   end
endmodule

// File: rtl/bfu_field.sv
module bfu_field #(
   parameter int W  = 32,
   parameter int AW = $clog2(W)
) (
   input  logic [W-1:0]  rot_val,
   input  logic [W-1:0]  dst_old,
   input  logic [AW-1:0] pos,
   input  logic [AW-1:0] size_m1,
   input  logic          deposit,
   output logic [W-1:0]  dout
);
   logic [W-1:0] low_mask;
   logic [W-1:0] place_mask;

   assign low_mask   = {W{1'b1}} >> ((W - 1) - int'(size_m1));
   assign place_mask = low_mask << pos;
   assign dout = deposit ? ((dst_old & ~place_mask) | (rot_val & place_mask))
                         : (rot_val & low_mask);
endmodule

// File: rtl/bfu_top.sv
module bfu_top
   import bfu_pkg::*;
#(
   parameter int W  = 32,
   localparam int AW = $clog2(W),
   localparam int CW = AW + 1
) (
   input  logic [3:0]    op_sel,
   input  logic [W-1:0]  src_a,
   input  logic [W-1:0]  src_b,
   input  logic [AW-1:0] pos_imm,
   input  logic [AW-1:0] size_imm,
   output logic [W-1:0]  result
);
   localparam int NHALF = W / 16;

   if (W < 16 || (W % 16) != 0 || (W & (W - 1)) != 0) begin : g_bad_w
      $error("bfu_top: W must be a power of two of at least 16");
   end

   bfu_op_e      op;
   logic [CW-1:0] lead_cnt [2];
   logic [W-1:0]  hswap;
   logic [AW-1:0] rot_amt;
   logic [W-1:0]  rot_val;
   logic [W-1:0]  field_val;

   assign op = bfu_op_e'(op_sel);

   // index 0 counts ones, index 1 counts zeros
   for (genvar k = 0; k < 2; k++) begin : g_lead
      bfu_lead_count #(.W(W), .CW(CW)) u_cnt (
         .vec   (src_a),
         .match (k == 0),
         .cnt   (lead_cnt[k])
      );
   end

   for (genvar h = 0; h < NHALF; h++) begin : g_hswap
      assign hswap[16*h +: 16] = {src_a[16*h +: 8], src_a[16*h+8 +: 8]};
   end

   always_comb begin
      case (op)
         OP_DEPOSIT: rot_amt = AW'(0) - pos_imm;
         OP_RORV:    rot_amt = src_b[AW-1:0];
         default:    rot_amt = pos_imm;
      endcase
   end

   bfu_rotr #(.W(W), .AW(AW)) u_rot (
      .din  (src_a),
      .amt  (rot_amt),
      .dout (rot_val)
   );

   bfu_field #(.W(W), .AW(AW)) u_field (
      .rot_val (rot_val),
      .dst_old (src_b),
      .pos     (pos_imm),
      .size_m1 (size_imm),
      .deposit (op == OP_DEPOSIT),
      .dout    (field_val)
   );

   always_comb begin
      case (op)
         OP_LEAD1:   result = W'(lead_cnt[0]);
         OP_LEAD0:   result = W'(lead_cnt[1]);
         OP_SXT8:    result = {{(W-8){src_a[7]}}, src_a[7:0]};
         OP_SXT16:   result = {{(W-16){src_a[15]}}, src_a[15:0]};
         OP_HSWAP:   result = hswap;
         OP_XTRACT,
         OP_DEPOSIT: result = field_val;
         OP_RORI,
         OP_RORV:    result = rot_val;
         default:    result = '0;
      endcase
   end

   // R6/R7: field contents checked against the unrotated source at the ports
   logic [W-1:0] chk_mask;
   logic         chk_legal;
   assign chk_mask  = {W{1'b1}} >> ((W - 1) - int'(size_imm));
   assign chk_legal = (int'(pos_imm) + int'(size_imm) + 1) <= W;

   always_comb begin
      if (!$isunknown({op_sel, src_a, src_b, pos_imm, size_imm}) && chk_legal) begin
         if (op == OP_XTRACT)
            assert_xtract_field_R6: assert (result == ((src_a >> pos_imm) & chk_mask));
         if (op == OP_DEPOSIT)
            assert_deposit_field_R7: assert (((result >> pos_imm) & chk_mask) == (src_a & chk_mask));
      end
   end
endmodule

// File: tb/bfu_top_bench.sv
module bfu_top_bench;
   localparam int W = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_sel = '0;
   logic [31:0] src_a = '0;
   logic [31:0] src_b = '0;
   logic [4:0]  pos_imm = '0;
   logic [4:0]  size_imm = '0;
   logic [31:0] result;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bfu_top #(.W(W)) u_bfu_top (
      .op_sel(op_sel), .src_a(src_a), .src_b(src_b),
      .pos_imm(pos_imm), .size_imm(size_imm), .result(result)
   );

   function automatic logic [31:0] ref_lead(logic [31:0] a, logic m);
      logic [31:0] n = 0;
      for (int i = 31; i >= 0; i--) begin
         if (a[i] != m) return n;
         n++;
      end
      return n;
   endfunction

   function automatic logic [31:0] ref_rotr(logic [31:0] a, int n);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = a[(i + n) % 32];
      return r;
   endfunction

   function automatic logic [31:0] ref_model(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                             logic [4:0] p, logic [4:0] s);
      logic [31:0] r = 0;
      int sz = int'(s) + 1;
      case (op)
         4'd0: r = ref_lead(a, 1'b1);
         4'd1: r = ref_lead(a, 1'b0);
         4'd2: begin r[7:0] = a[7:0];   for (int i = 8;  i < 32; i++) r[i] = a[7];  end
         4'd3: begin r[15:0] = a[15:0]; for (int i = 16; i < 32; i++) r[i] = a[15]; end
         4'd4: begin r[31:24] = a[23:16]; r[23:16] = a[31:24]; r[15:8] = a[7:0]; r[7:0] = a[15:8]; end
         4'd5: for (int i = 0; i < sz; i++) r[i] = a[int'(p) + i];
         4'd6: begin r = b; for (int i = 0; i < sz; i++) r[int'(p) + i] = a[i]; end
         4'd7: r = ref_rotr(a, int'(p));
         4'd8: r = ref_rotr(a, int'(b[4:0]));
         default: r = 0;
      endcase
      return r;
   endfunction

   task automatic apply(string tag, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                        logic [4:0] p, logic [4:0] s);
      logic [31:0] exp;
      @(negedge clk);
      op_sel = op; src_a = a; src_b = b; pos_imm = p; size_imm = s;
      exp = ref_model(op, a, b, p, s);
      #2;
      checks++;
      if (result !== exp) begin
         failures++;
         $display("FAIL %s op=%0d a=%h b=%h p=%0d s=%0d actual=%h expected=%h",
                  tag, op, a, b, p, s, result, exp);
      end
   endtask

   task automatic legal_field(output logic [4:0] p, output logic [4:0] s);
      int sz = int'($urandom % 32) + 1;
      int ps = int'($urandom % (33 - sz));
      s = 5'(sz - 1);
      p = 5'(ps);
   endtask

   initial begin
      logic [4:0] p, s;
      void'($urandom(32'd2718));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // reset state: all-zero operands, op 0
      apply("R1 reset", 4'd0, 32'h0, 32'h0, 5'd0, 5'd0);

      apply("R1 all ones", 4'd0, 32'hFFFF_FFFF, 0, 0, 0);
      apply("R1 top bit zero", 4'd0, 32'h7FFF_FFFF, 0, 0, 0);
      apply("R1 run of 4", 4'd0, 32'hF0FF_FFFF, 0, 0, 0);
      apply("R2 all zeros", 4'd1, 32'h0, 0, 0, 0);
      apply("R2 lowest bit", 4'd1, 32'h1, 0, 0, 0);
      apply("R2 top bit set", 4'd1, 32'h8000_0000, 0, 0, 0);
      apply("R3 negative byte", 4'd2, 32'h1234_5680, 0, 0, 0);
      apply("R3 positive byte", 4'd2, 32'hFFFF_FF7F, 0, 0, 0);
      apply("R4 negative half", 4'd3, 32'h0000_8001, 0, 0, 0);
      apply("R4 positive half", 4'd3, 32'hFFFF_7FFF, 0, 0, 0);
      apply("R5 swap", 4'd4, 32'h1122_3344, 0, 0, 0);
      apply("R6 full width", 4'd5, 32'hDEAD_BEEF, 0, 5'd0, 5'd31);
      apply("R6 top bit", 4'd5, 32'h8000_0000, 0, 5'd31, 5'd0);
      apply("R7 top byte", 4'd6, 32'h0000_00A5, 32'h1234_5678, 5'd24, 5'd7);
      apply("R7 single bit low", 4'd6, 32'h0000_0001, 32'hFFFF_FFFE, 5'd0, 5'd0);
      apply("R8 by zero", 4'd7, 32'hCAFE_F00D, 0, 5'd0, 0);
      apply("R8 by one wraps", 4'd7, 32'h0000_0001, 0, 5'd1, 0);
      apply("R9 upper bits ignored", 4'd8, 32'h1234_5678, 32'hFFFF_FFE4, 0, 0);
      apply("R9 amount 31", 4'd8, 32'h8000_0001, 32'h0000_001F, 0, 0);
      for (int op = 9; op < 16; op++)
         apply("R10 unused code", 4'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31, 5'd31);

      // shared rotator: same operands, four operations on consecutive cycles
      for (int n = 0; n < 150; n++) begin
         logic [31:0] a = $urandom;
         logic [31:0] b = $urandom;
         legal_field(p, s);
         apply("R6 shared", 4'd5, a, b, p, s);
         apply("R7 shared", 4'd6, a, b, p, s);
         apply("R8 shared", 4'd7, a, b, p, s);
         apply("R9 shared", 4'd8, a, b, p, s);
      end

      for (int n = 0; n < 100; n++) begin
         logic [31:0] a = $urandom;
         int sh = int'($urandom % 33);
         logic [31:0] ones = (sh == 32) ? 32'hFFFF_FFFF : ~(32'hFFFF_FFFF >> sh);
         apply("R1 random", 4'd0, ones | (a >> (sh + 1)), 0, 0, 0);
         apply("R2 random", 4'd1, (~ones) & (a >> (sh + 1)) | (sh == 32 ? 32'h0 : (32'h1 << (31 - sh))), 0, 0, 0);
         apply("R3 random", 4'd2, a, 0, 0, 0);
         apply("R4 random", 4'd3, a, 0, 0, 0);
         apply("R5 random", 4'd4, a, 0, 0, 0);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule